// File: doc/BRIEF.md
# Descriptor Ring Transmit DMA

This block is a single-channel DMA engine that walks a closed ring of buffer descriptors held in a word-addressed memory. Software places descriptors in memory, loads the current-descriptor pointer, and then writes the tail pointer. The engine processes every descriptor from the current one up to and including the one the tail names. For each descriptor it reads the buffer and sends its words out on a stream port. It then marks the descriptor done by setting a bit in the descriptor's flag word.

A frame may cover several consecutive descriptors. A start flag marks the first of them and an end flag marks the last. Completed frames feed a small interrupt unit. That unit raises a coalescing interrupt when enough frames have finished, and a delay interrupt when finished frames have waited too long. Both are reported through a status register that is cleared by writing ones.

If the engine fetches a descriptor that is already marked done, it flags an error and freezes until a soft reset.

Top module: `sg_ring_dma`

## Requirements
- R1: After reset every register reads 0, `irq` is low, and no memory request or stream beat is issued.
- R2: A write to the tail register (address 2) starts a walk from the current descriptor (address 1, writable only while idle) through the descriptor at the tail address, inclusive. Descriptors beyond the tail are not touched. A tail write made during a walk extends it.
- R3: A descriptor is four words at its base address. Offset 0 holds the next descriptor, offset 1 the buffer address, offset 2 the length in words, and offset 3 the flag word.
- R4: Each descriptor's buffer words go out on the stream in address order, one per cycle. A zero-length descriptor produces no beats but still completes.
- R5: In the flag word, bit 0 is start, bit 1 is end and bit 31 is done. `st_first` marks the first beat of a start descriptor and `st_last` marks the final beat of an end descriptor.
- R6: After its data, a descriptor's flag word is written back with bit 31 set and the other bits kept. The current pointer then takes the descriptor's next address.
- R7: With control bit 2 set, status bit 0 is set when the number of completed end descriptors reaches the threshold in control bits 23:16. The count then restarts.
- R8: With control bit 1 set, status bit 1 is set when end completions are pending and none has arrived for control bits 31:24 plus one cycles.
- R9: Status (address 3) is write-one-to-clear. Writing back the value read clears exactly the bits that were set.
- R10: Fetching a descriptor whose done bit is already set sets status bit 7. The engine then moves no data, writes nothing back and ignores tail writes until a soft reset. A soft reset is a control write with bit 3 set, which clears status and reads back as 0.
- R11: `irq` is high when control bit 0 is set and any status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 current, 2 tail, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write (else read, data the next cycle) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the request |
| st_valid | output | 1 | Stream beat valid |
| st_first | output | 1 | First beat of a frame |
| st_last | output | 1 | Last beat of a frame |
| st_data | output | 32 | Stream beat data |
| irq | output | 1 | Interrupt request |

## Verification
A tail write is registered at one edge, and the first descriptor read is issued two cycles later. Each stream beat appears the cycle after its buffer read, so the bench holds the expected beats in a queue and compares every valid beat on the falling edge. Descriptor write-back, pointer and status results are read only after a settle time well beyond the longest walk. The delay interrupt falls due delay-plus-one cycles after the control write that enables it, so the bench samples it once well before that cycle and once well after.

// File: rtl/sg_ring_dma.sv
module sg_ring_dma #(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          st_valid,
  output logic          st_first,
  output logic          st_last,
  output logic [31:0]   st_data,
  output logic          irq
);
  localparam int LW = 16;
  localparam logic [AW-1:0] OFS_BUF = AW'(1);
  localparam logic [AW-1:0] OFS_LEN = AW'(2);
  localparam logic [AW-1:0] OFS_FLG = AW'(3);

  typedef enum logic [3:0] {S_IDLE, S_F0, S_F1, S_F2, S_F3, S_CHK, S_MOVE, S_WB, S_HALT} st_t;
  st_t state;

  logic [31:0]   ctrl;
  logic [AW-1:0] cur, tail, d_next, d_buf;
  logic [LW-1:0] d_len, idx;
  logic [31:0]   d_flg;
  logic          go_req;
  logic [CW-1:0] cnt, tmr;
  logic          s_coal, s_dly, s_err;

  wire wr_ctl  = reg_wr && reg_addr == 2'd0;
  wire wr_cur  = reg_wr && reg_addr == 2'd1;
  wire wr_tail = reg_wr && reg_addr == 2'd2;
  wire wr_stat = reg_wr && reg_addr == 2'd3;
  wire srst    = wr_ctl && reg_wdata[3];

  wire ctl_ie   = ctrl[0];
  wire ctl_dly  = ctrl[1];
  wire ctl_coal = ctrl[2];
  wire [CW-1:0] thr  = ctrl[16 +: CW];
  wire [CW-1:0] dval = ctrl[24 +: CW];

  wire last_desc = (cur == tail);
  wire more      = (idx < d_len);
  wire issue     = (state == S_MOVE) && more;
  wire evt       = (state == S_WB) && d_flg[1];
  wire [CW:0] cnt_inc = {1'b0, cnt} + (CW+1)'(1);
  wire set_coal  = evt && ctl_coal && (cnt_inc >= {1'b0, thr});
  wire set_dly   = !evt && ctl_dly && (cnt != '0) && (tmr == dval);
  wire set_err   = (state == S_CHK) && mem_rdata[31];

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_wdata = d_flg | 32'h8000_0000;
    case (state)
      S_F0:   mem_req = 1'b1;
      S_F1:   begin mem_req = 1'b1; mem_addr = cur + OFS_BUF; end
      S_F2:   begin mem_req = 1'b1; mem_addr = cur + OFS_LEN; end
      S_F3:   begin mem_req = 1'b1; mem_addr = cur + OFS_FLG; end
      S_MOVE: begin mem_req = more; mem_addr = d_buf + idx[AW-1:0]; end
      S_WB:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur + OFS_FLG; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx <= '0;
      d_next <= '0; d_buf <= '0; d_len <= '0; d_flg <= '0;
    end else if (srst) begin
      state <= S_IDLE;
      idx <= '0;
    end else begin
      case (state)
        S_IDLE: if (go_req) state <= S_F0;
        S_F0:   state <= S_F1;
        S_F1:   begin d_next <= mem_rdata[AW-1:0]; state <= S_F2; end
        S_F2:   begin d_buf <= mem_rdata[AW-1:0]; state <= S_F3; end
        S_F3:   begin d_len <= mem_rdata[LW-1:0]; state <= S_CHK; end
        S_CHK:  begin
          d_flg <= mem_rdata;
          idx <= '0;
          state <= mem_rdata[31] ? S_HALT : S_MOVE;
        end
        S_MOVE: if (more) idx <= idx + LW'(1); else state <= S_WB;
        S_WB:   state <= last_desc ? S_IDLE : S_F0;
        default: state <= S_HALT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; cur <= '0; tail <= '0; go_req <= 1'b0;
    end else begin
      if (wr_ctl) ctrl <= reg_wdata & ~32'h8;
      if (wr_cur && state == S_IDLE) cur <= reg_wdata[AW-1:0];
      else if (state == S_WB) cur <= d_next;
      if (wr_tail) tail <= reg_wdata[AW-1:0];
      if (srst) go_req <= 1'b0;
      else if (wr_tail) go_req <= 1'b1;
      else if (state == S_IDLE || (state == S_WB && last_desc)) go_req <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_valid <= 1'b0; st_first <= 1'b0; st_last <= 1'b0;
    end else begin
      st_valid <= issue;
      st_first <= issue && idx == '0 && d_flg[0];
      st_last  <= issue && idx == d_len - LW'(1) && d_flg[1];
    end
  end
  assign st_data = mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; tmr <= '0; s_coal <= 1'b0; s_dly <= 1'b0; s_err <= 1'b0;
    end else if (srst) begin
      cnt <= '0; tmr <= '0; s_coal <= 1'b0; s_dly <= 1'b0; s_err <= 1'b0;
    end else begin
      if (evt) cnt <= set_coal ? '0 : cnt_inc[CW-1:0];
      else if (set_dly) cnt <= '0;
      if (evt || set_dly) tmr <= '0;
      else if (ctl_dly && cnt != '0) tmr <= tmr + CW'(1);
      s_coal <= (s_coal && !(wr_stat && reg_wdata[0])) || set_coal;
      s_dly  <= (s_dly  && !(wr_stat && reg_wdata[1])) || set_dly;
      s_err  <= (s_err  && !(wr_stat && reg_wdata[7])) || set_err;
    end
  end

  assign irq = ctl_ie && (s_coal || s_dly || s_err);

  always_comb begin
    case (reg_addr)
      2'd0: reg_rdata = ctrl;
      2'd1: reg_rdata = 32'(cur);
      2'd2: reg_rdata = 32'(tail);
      default: reg_rdata = {24'd0, s_err, 5'd0, s_dly, s_coal};
    endcase
  end

  // R2
  start_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_F0 |-> $past(go_req || state == S_WB));
  // R4
  beat_after_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> $past(state == S_MOVE));
  // R6
  cur_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur) |-> $past(state == S_WB || wr_cur));
  // R10
  err_from_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_err) |-> $past(state == S_CHK));
  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[0] && !set_coal && !srst) |=> !s_coal);
endmodule

// File: tb/sim_sg_ring_dma.sv
module sim_sg_ring_dma;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_we;
  logic [7:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic st_valid, st_first, st_last, irq;
  logic [31:0] st_data;
  logic tb_we = 0;
  logic [7:0] tb_a = 0;
  logic [31:0] tb_d = 0;
  logic [31:0] mem [256];
  logic [33:0] expq [$];
  int checks = 0, fails = 0;
  logic done = 0;

  always #10 clk = ~clk;

  sg_ring_dma u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .st_valid(st_valid), .st_first(st_first), .st_last(st_last), .st_data(st_data), .irq(irq));

  always_ff @(posedge clk) begin
    if (tb_we) mem[tb_a] <= tb_d;
    else if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_req) mem_rdata <= mem[mem_addr];
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (mem_req && mem_we && mem_addr[3:0] != 4'd3) begin
        fails++;
        $display("FAIL R6: write to %h, expected only flag words", mem_addr);
      end
      if (st_valid) begin
        if (expq.size() == 0) begin
          fails++;
          $display("FAIL R4: actual beat %h expected none", st_data);
        end else begin
          logic [33:0] e;
          e = expq.pop_front();
          if ({st_first, st_last, st_data} !== e) begin
            fails++;
            $display("FAIL R4/R5: actual %h expected %h", {st_first, st_last, st_data}, e);
          end
        end
      end
    end
  end

  task automatic poke(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); tb_we = 1; tb_a = a; tb_d = d;
    @(negedge clk); tb_we = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic desc(input logic [7:0] b, input logic [7:0] nx, input logic [7:0] buf_a,
                      input logic [31:0] len, input logic [31:0] flg);
    poke(b, {24'd0, nx}); poke(b + 8'd1, {24'd0, buf_a});
    poke(b + 8'd2, len); poke(b + 8'd3, flg);
  endtask

  task automatic expect_beats(input logic [7:0] buf_a, input int n, input logic f, input logic l);
    for (int i = 0; i < n; i++)
      expq.push_back({f && i == 0, l && i == n - 1, 32'hA500_0000 | 32'(buf_a + 8'(i))});
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1
    check("R1 mem_req", 32'(mem_req), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 st_valid", 32'(st_valid), 0);
    rst_n = 1;
    for (int k = 0; k < 4; k++) begin
      rd(2'(k), v); check("R1 reg", v, 0);
    end
    for (int a = 8'h80; a < 8'hC0; a++) poke(8'(a), 32'hA500_0000 | 32'(a));
    desc(8'h10, 8'h20, 8'h80, 3, 32'h1);
    desc(8'h20, 8'h30, 8'h90, 2, 32'h2);
    desc(8'h30, 8'h40, 8'hA0, 0, 32'h3);
    desc(8'h40, 8'h10, 8'hB0, 1, 32'h3);

    // R2 R3 R4 R5 R6: two-descriptor frame, tail stops at second
    wr(0, 32'h0002_0005);
    wr(1, 32'h10);
    expect_beats(8'h80, 3, 1, 0);
    expect_beats(8'h90, 2, 0, 1);
    wr(2, 32'h20);
    repeat (60) @(negedge clk);
    check("R4 queue drained", 32'(expq.size()), 0);
    check("R6 D0 done", mem[8'h13], 32'h8000_0001);
    check("R6 D1 done", mem[8'h23], 32'h8000_0002);
    check("R2 D2 untouched", mem[8'h33], 32'h3);
    rd(1, v); check("R6 cur advanced", v, 32'h30);
    rd(3, v); check("R7 no coalesce yet", v, 0);
    check("R11 irq low", 32'(irq), 0);

    // R4 zero length, R7 coalesce at threshold 2, ring wrap
    expect_beats(8'hB0, 1, 1, 1);
    wr(2, 32'h40);
    repeat (60) @(negedge clk);
    check("R4 queue drained", 32'(expq.size()), 0);
    check("R4 zero-len completes", mem[8'h33], 32'h8000_0003);
    check("R6 D3 done", mem[8'h43], 32'h8000_0003);
    rd(1, v); check("R6 wrap", v, 32'h10);
    rd(3, v); check("R7 coalesce bit", v, 32'h1);
    check("R11 irq high", 32'(irq), 1);
    // R9
    wr(3, v);
    rd(3, v); check("R9 cleared", v, 0);
    check("R11 irq after clear", 32'(irq), 0);

    // R8 delay with one completion pending, delay value 10
    wr(0, 32'h0A00_0003);
    repeat (3) @(negedge clk);
    rd(3, v); check("R8 not yet", v, 0);
    repeat (20) @(negedge clk);
    rd(3, v); check("R8 delay bit", v, 32'h2);
    wr(3, 32'h2);
    rd(3, v); check("R9 delay cleared", v, 0);

    // R10 error on a descriptor already done
    wr(2, 32'h10);
    repeat (30) @(negedge clk);
    rd(3, v); check("R10 error bit", v, 32'h80);
    check("R11 irq on error", 32'(irq), 1);
    rd(1, v); check("R10 cur held", v, 32'h10);
    wr(2, 32'h10);
    repeat (30) @(negedge clk);
    check("R10 no write-back", mem[8'h13], 32'h8000_0001);
    wr(0, 32'h0000_0009);
    rd(3, v); check("R10 soft reset clears", v, 0);
    rd(0, v); check("R10 reset bit reads 0", v, 32'h1);

    // R2 R5 restart after recovery, start without end
    poke(8'h13, 32'h1);
    expect_beats(8'h80, 3, 1, 0);
    wr(2, 32'h10);
    repeat (40) @(negedge clk);
    check("R4 queue drained", 32'(expq.size()), 0);
    check("R6 D0 done again", mem[8'h13], 32'h8000_0001);
    rd(1, v); check("R2 cur after", v, 32'h20);
    done = 1;
    summary();
  end
endmodule